// File: doc/BRIEF.md
# Fixed-Limit Watchdog Timer

This block is a 15-bit supervision counter that advances on a divided clock and must be serviced by software before it climbs to the fixed terminal value 0x7CFF. If software stops servicing it, the block raises a one-cycle reset request for the system reset logic and sets a sticky trip flag. Software can read that flag after the restart to learn why the restart happened. The block does not generate the system reset itself.

There are two ways to start the counter. A start pin can be held high while the external reset is asserted, or software can write an enable bit. Once the counter runs, software cannot stop it; only the external reset does. Servicing takes two consecutive register writes: an arm key, then a confirm key. The refresh loads the upper seven counter bits from a programmable reload register and clears the lower eight bits. It also restarts the clock divider, which divides by 24 or by 384 as a select bit chooses.

The register bus is a single-cycle write port plus a combinational read port with two address bits. Address 0 is the control register: bit 0 is the enable/running bit and bit 1 is the divider select. Address 1 holds the reload value. Address 2 is the service register. Address 3 holds the trip flag and the high counter bits.

Top module: `wdog_core`

## Requirements
- R1: After the external reset (`rst_n` low), the counter, reload value, divider select and trip flag are all zero, the counter is stopped, `rd_data` reads 0x00 at every address, and `wdt_rst_req` is low.
- R2: While running with divider select 0, the counter increments once every 24 clock cycles.
- R3: While running with divider select 1 (control bit 1), the counter increments once every 384 clock cycles.
- R4: If `hw_start` is high while reset is asserted, the counter starts on its own after release. The first increment comes 27 clock edges after `rst_n` rises, with divider select 0.
- R5: Writing address 0 with bit 0 set starts the counter. While the counter is stopped, nothing except a refresh changes the count.
- R6: Once the counter runs, no write stops it. A write of bit 0 = 0 to address 0 leaves the running bit (address 0, bit 0) at 1. Only the external reset clears it.
- R7: In the cycle in which the running count equals 0x7CFF, `wdt_rst_req` is high for exactly one cycle. On the next edge the trip flag sets, the count reloads to {reload, 0x00}, the divider restarts and the counter keeps running.
- R8: The trip flag (address 3, bit 7) stays set through its own reset request. A write to address 3 with bit 7 = 0 clears it; a write with bit 7 = 1 leaves it set. The external reset also clears it.
- R9: A refresh sets the count to {reload[6:0], 0x00} and restarts the divider, so the next increment comes one full divider period later. A refresh also loads the count when the counter is stopped.
- R10: A refresh happens only when a write of 0x5A to address 2 directly follows a write of 0xA5 to address 2. Any other write in between cancels the arm, and a lone 0x5A does nothing.
- R11: Refreshing again before the count reaches 0x7CFF keeps `wdt_rst_req` low indefinitely.
- R12: Read map:
  - address 0 reads {6'b0, select, running};
  - address 1 reads {1'b0, reload[6:0]}, keeping only the low 7 bits written;
  - address 2 reads count[7:0];
  - address 3 reads {flag, count[14:8]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | External reset, asynchronous assert, active low |
| hw_start | input | 1 | Start-at-boot request, sampled while reset is asserted |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data, combinational from `rd_addr` |
| wdt_rst_req | output | 1 | One-cycle internal reset request on expiry |
| trip_flag | output | 1 | Sticky expiry status flag |

## Verification
The properties assume that `wr_addr` and `wr_data` hold known values whenever `wr_en` is high. They also assume that `rst_n` stays low for at least two clock edges, so the synchronised reset and the boot-start sample both settle. The bench keeps to this: it changes every input on the falling edge, drives each write for one cycle only, and holds reset low for three edges. The expected counter values come from the divide ratios and the 0x7CFF limit alone; long waits are avoided by loading the high bits from the reload register, so the counter starts 255 steps below the limit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned ADR_W = 2;
  localparam int unsigned LOW_W = 8;

  typedef enum logic [ADR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_KICK   = 2'd2,
    REG_STAT   = 2'd3
  } reg_addr_e;

  localparam logic [BUS_W-1:0] KEY_ARM     = 8'hA5;
  localparam logic [BUS_W-1:0] KEY_CONFIRM = 8'h5A;
endpackage

// File: rtl/wdog_rstsync.sv
module wdog_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b0;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 15,
  parameter int unsigned RLD_W = CNT_W - LOW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [ADR_W-1:0] rd_addr,
  output logic [BUS_W-1:0] rd_data,
  input  logic             running,
  input  logic             flag,
  input  logic [CNT_W-1:0] count,
  output logic             presc_sel,
  output logic [RLD_W-1:0] reload,
  output logic             sw_start,
  output logic             refresh,
  output logic             flag_clr
);
  logic             sel_q, sel_d;
  logic [RLD_W-1:0] reload_q, reload_d;
  logic             armed_q, armed_d;

  // next-state decode of the write port
  always_comb begin
    sel_d    = sel_q;
    reload_d = reload_q;
    armed_d  = armed_q;
    if (wr_en) begin
      // any write other than the arm key drops a pending arm
      armed_d = (wr_addr == REG_KICK) && (wr_data == KEY_ARM);
      case (wr_addr)
        REG_CTRL:   sel_d    = wr_data[1];
        REG_RELOAD: reload_d = wr_data[RLD_W-1:0];
        default:    ;
      endcase
    end
  end

  assign sw_start = wr_en && (wr_addr == REG_CTRL) && wr_data[0];
  assign refresh  = wr_en && (wr_addr == REG_KICK) && (wr_data == KEY_CONFIRM) && armed_q;
  assign flag_clr = wr_en && (wr_addr == REG_STAT) && !wr_data[BUS_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      reload_q <= '0;
      armed_q  <= 1'b0;
    end else if (wr_en) begin
      sel_q    <= sel_d;
      reload_q <= reload_d;
      armed_q  <= armed_d;
    end
  end

  assign presc_sel = sel_q;
  assign reload    = reload_q;

  // read mux
  always_comb begin
    rd_data = '0;
    case (rd_addr)
      REG_CTRL: begin
        rd_data[0] = running;
        rd_data[1] = sel_q;
      end
      REG_RELOAD: rd_data[RLD_W-1:0] = reload_q;
      REG_KICK:   rd_data = count[LOW_W-1:0];
      REG_STAT: begin
        rd_data[RLD_W-1:0] = count[CNT_W-1:LOW_W];
        rd_data[BUS_W-1]   = flag;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int unsigned DIV_FAST = 24,
  parameter int unsigned DIV_SLOW = 384
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel,
  input  logic clear,
  output logic tick
);
  localparam int unsigned DIV_MAX   = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int unsigned PW        = $clog2(DIV_MAX);
  localparam logic [PW-1:0] LAST_FAST = PW'(DIV_FAST - 1);
  localparam logic [PW-1:0] LAST_SLOW = PW'(DIV_SLOW - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic [PW-1:0] last;
  logic          pcnt_en;

  assign last = sel ? LAST_SLOW : LAST_FAST;
  // >= covers a select change while the phase is beyond the new limit
  assign tick = run && (pcnt_q >= last);

  always_comb begin
    pcnt_d = pcnt_q + PW'(1);
    if (clear || !run || tick) pcnt_d = '0;
  end

  assign pcnt_en = run || clear || (pcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 15,
  parameter int unsigned RLD_W    = 7,
  parameter int unsigned TRIP_VAL = 32'h7CFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_start,
  input  logic             sw_start,
  input  logic             refresh,
  input  logic             tick,
  input  logic             flag_clr,
  input  logic [RLD_W-1:0] reload,
  output logic             running,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             rst_req,
  output logic             restart
);
  localparam int unsigned LOW_W = CNT_W - RLD_W;
  localparam logic [CNT_W-1:0] TRIP = CNT_W'(TRIP_VAL);

  logic             start_lat_q;
  logic             boot_done_q;
  logic             running_q, running_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             flag_q, flag_d;
  logic             trip;
  logic             cnt_en;

  // boot-start sample: captured only while the reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) start_lat_q <= hw_start;
  end

  assign trip = running_q && (count_q == TRIP);

  always_comb begin
    running_d = running_q | sw_start | (!boot_done_q & start_lat_q);
    count_d   = count_q + CNT_W'(1);
    if (refresh || trip) count_d = {reload, {LOW_W{1'b0}}};
    flag_d = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (trip)     flag_d = 1'b1;
  end

  assign cnt_en = refresh || trip || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_done_q <= 1'b0;
      running_q   <= 1'b0;
      count_q     <= '0;
      flag_q      <= 1'b0;
    end else begin
      boot_done_q <= 1'b1;
      running_q   <= running_d;
      flag_q      <= flag_d;
      if (cnt_en) count_q <= count_d;
    end
  end

  assign running = running_q;
  assign count   = count_q;
  assign flag    = flag_q;
  assign rst_req = trip;
  assign restart = refresh || trip;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W       = 15,
  parameter int unsigned TRIP_VAL    = 32'h7CFF,
  parameter int unsigned DIV_FAST    = 24,
  parameter int unsigned DIV_SLOW    = 384,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_start,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       wdt_rst_req,
  output logic       trip_flag
);
  localparam int unsigned RLD_W = CNT_W - LOW_W;

  logic             rst_sync_n;
  logic             running;
  logic [CNT_W-1:0] count;
  logic             presc_sel;
  logic [RLD_W-1:0] reload;
  logic             sw_start;
  logic             refresh;
  logic             flag_clr;
  logic             tick;
  logic             restart;

  wdog_rstsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  wdog_regif #(.CNT_W(CNT_W), .RLD_W(RLD_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .running   (running),
    .flag      (trip_flag),
    .count     (count),
    .presc_sel (presc_sel),
    .reload    (reload),
    .sw_start  (sw_start),
    .refresh   (refresh),
    .flag_clr  (flag_clr)
  );

  wdog_prescaler #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (running),
    .sel   (presc_sel),
    .clear (restart),
    .tick  (tick)
  );

  wdog_counter #(.CNT_W(CNT_W), .RLD_W(RLD_W), .TRIP_VAL(TRIP_VAL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .hw_start (hw_start),
    .sw_start (sw_start),
    .refresh  (refresh),
    .tick     (tick),
    .flag_clr (flag_clr),
    .reload   (reload),
    .running  (running),
    .count    (count),
    .flag     (trip_flag),
    .rst_req  (wdt_rst_req),
    .restart  (restart)
  );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             running,
  input logic             tick,
  input logic             refresh,
  input logic             rst_req,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             flag_clr
);
  assert_run_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  assert_req_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> flag);

  assert_req_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !flag_clr |=> flag);

  assert_refresh_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (count[7:0] == 8'h00));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !refresh && !rst_req |=> count == $past(count) + CNT_W'(1));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !running && !refresh |=> $stable(count));
endmodule

bind wdog_core wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .running  (running),
  .tick     (tick),
  .refresh  (refresh),
  .rst_req  (wdt_rst_req),
  .count    (count),
  .flag     (trip_flag),
  .flag_clr (flag_clr)
);

// File: tb/sim_wdog_core.sv
`timescale 1ns/1ps
module sim_wdog_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       hw_start;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       wdt_rst_req;
  logic       trip_flag;

  int n_tests = 0;
  int n_fail  = 0;
  int req_seen = 0;

  always #4 clk = ~clk;

  wdog_core u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .hw_start    (hw_start),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wdt_rst_req (wdt_rst_req),
    .trip_flag   (trip_flag)
  );

  always @(negedge clk) if (wdt_rst_req === 1'b1) req_seen++;

  // {write addr, write data, read addr, expected read}
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    {2'd1, 8'h12, 2'd1, 8'h12},
    {2'd0, 8'h02, 2'd0, 8'h02},
    {2'd0, 8'h00, 2'd0, 8'h00},
    {2'd1, 8'hFF, 2'd1, 8'h7F},
    {2'd2, 8'hA5, 2'd3, 8'h00},
    {2'd2, 8'h5A, 2'd3, 8'h7F},
    {2'd1, 8'h05, 2'd3, 8'h7F},
    {2'd2, 8'hA5, 2'd3, 8'h7F},
    {2'd0, 8'h00, 2'd3, 8'h7F},
    {2'd2, 8'h5A, 2'd3, 8'h7F},
    {2'd2, 8'hA5, 2'd3, 8'h7F},
    {2'd2, 8'hA5, 2'd3, 8'h7F},
    {2'd2, 8'h5A, 2'd3, 8'h05},
    {2'd3, 8'h80, 2'd2, 8'h00},
    {2'd1, 8'h7C, 2'd0, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic kick();
    wr(2'd2, 8'hA5);
    wr(2'd2, 8'h5A);
  endtask

  task automatic do_reset(input logic hs);
    @(negedge clk);
    hw_start = hs;
    rst_n = 1'b0;
    adv(3);
    rst_n = 1'b1;
    adv(4);
    hw_start = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired before the bench completed");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; hw_start = 1'b0; wr_en = 1'b0;
    wr_addr = 2'd0; wr_data = 8'h00; rd_addr = 2'd0;

    // R1: reset state
    do_reset(1'b0);
    chk_rd("R1 ctrl", 2'd0, 8'h00);
    chk_rd("R1 reload", 2'd1, 8'h00);
    chk_rd("R1 count low", 2'd2, 8'h00);
    chk_rd("R1 status", 2'd3, 8'h00);
    chk("R1 rst_req", {31'h0, wdt_rst_req}, 32'h0);
    chk("R1 trip_flag", {31'h0, trip_flag}, 32'h0);

    // R12 R10 R9 R5: register vectors, counter stopped
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:18], VEC[i][17:10]);
      chk_rd($sformatf("R12 R10 R9 R5 vector %0d", i), VEC[i][9:8], VEC[i][7:0]);
    end

    // R5 software start, R6 lock
    wr(2'd0, 8'h01);
    chk_rd("R5 running after enable", 2'd0, 8'h01);
    wr(2'd0, 8'h00);
    chk_rd("R6 still running after zero write", 2'd0, 8'h01);
    wr(2'd0, 8'h02);
    chk_rd("R6 R12 select written, still running", 2'd0, 8'h03);
    wr(2'd0, 8'h00);

    // R9 R2: refresh to 0x7C00, fast rate
    kick();
    chk_rd("R9 high bits from reload", 2'd3, 8'h7C);
    chk_rd("R9 low bits cleared", 2'd2, 8'h00);
    adv(23);
    chk_rd("R2 no step before 24 cycles", 2'd2, 8'h00);
    adv(1);
    chk_rd("R2 step at 24 cycles", 2'd2, 8'h01);
    adv(48);
    chk_rd("R2 step every 24 cycles", 2'd2, 8'h03);

    // R7 expiry at 0x7CFF after 255 steps
    adv(6120 - 72 - 1);
    chk("R7 no request before limit", {31'h0, wdt_rst_req}, 32'h0);
    adv(1);
    chk("R7 request at limit", {31'h0, wdt_rst_req}, 32'h1);
    chk_rd("R7 count at limit low", 2'd2, 8'hFF);
    chk_rd("R7 count at limit high", 2'd3, 8'h7C);
    adv(1);
    chk("R7 request one cycle", {31'h0, wdt_rst_req}, 32'h0);
    chk_rd("R7 flag set, count reloaded", 2'd3, 8'hFC);
    chk_rd("R7 low cleared after trip", 2'd2, 8'h00);
    chk_rd("R7 still running", 2'd0, 8'h01);
    chk("R7 single pulse seen", req_seen, 32'd1);

    // R8 flag clear rules
    wr(2'd3, 8'h80);
    chk("R8 flag kept on bit7=1 write", {31'h0, trip_flag}, 32'h1);
    wr(2'd3, 8'h00);
    chk("R8 flag cleared on bit7=0 write", {31'h0, trip_flag}, 32'h0);

    // R11 repeated refresh keeps request low
    for (int k = 0; k < 3; k++) begin
      kick();
      adv(6000);
    end
    chk("R11 no request while serviced", req_seen, 32'd1);
    chk("R11 flag still clear", {31'h0, trip_flag}, 32'h0);

    // R3 slow rate
    wr(2'd0, 8'h02);
    kick();
    adv(383);
    chk_rd("R3 no step before 384 cycles", 2'd2, 8'h00);
    adv(1);
    chk_rd("R3 step at 384 cycles", 2'd2, 8'h01);

    // R4 start pin during reset
    do_reset(1'b1);
    chk_rd("R4 running after boot start", 2'd0, 8'h01);
    adv(22);
    chk_rd("R4 no step before edge 27", 2'd2, 8'h00);
    adv(1);
    chk_rd("R4 first step at edge 27", 2'd2, 8'h01);

    // R8 R6: external reset clears flag and running
    wr(2'd1, 8'h7C);
    kick();
    adv(6125);
    chk("R7 flag after second expiry", {31'h0, trip_flag}, 32'h1);
    do_reset(1'b0);
    chk("R8 flag cleared by external reset", {31'h0, trip_flag}, 32'h0);
    chk_rd("R6 stopped only by external reset", 2'd0, 8'h00);
    chk_rd("R1 status zero after reset", 2'd3, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule